// File: doc/BRIEF.md
# Physical Address Cacheability Filter

This block sits between address translation and the memory system. Each cycle it may receive one translated physical address together with a valid strobe and a flag that says whether the access is an instruction fetch. It decides whether the access targets cacheable memory or uncached device space. For device-space accesses it sets the uncacheable and strict-ordering attributes and rewrites the address. It also rejects two cases: accesses to the unimplemented internal-register window, and instruction fetches that would land in device space. Fetches to device space are refused because reading a device register can destroy state that clears on read.

The uncached attribute is carried by one high physical address bit. Inside uncached space, a tag field just below that bit picks out the register window. In every other uncached access a fixed field below the uncached bit is cleared before the address goes on. The decision is combinational and the outputs are registered, so results appear one clock after the request. The output data fields load only on valid requests and hold their values otherwise.

Top module: `pa_cache_filter`

## Requirements
- R1: While reset is active, out_valid, out_paddr, out_uncache, out_strict and out_fault are all zero.
- R2: out_valid is in_valid delayed by exactly one clock. The registered results for a request appear in the same cycle as that out_valid.
- R3: When in_paddr bit 43 is 0, out_paddr equals in_paddr, out_uncache and out_strict are 0, and out_fault is 0. This holds for fetches and for data accesses.
- R4: When bit 43 is 1 and bits 42:40 equal 3'b111 (the register window), out_fault is 1 (unimplemented space) for both fetch and data. In that case out_uncache and out_strict are 0 and out_paddr equals in_paddr unchanged.
- R5: When bit 43 is 1 and bits 42:40 are not 3'b111, out_uncache and out_strict are both 1.
- R6: In the R5 case, out_paddr has bits 42:35 cleared, and every other bit, including bit 43, is copied from in_paddr.
- R7: In the R5 case with in_ifetch = 1, out_fault is 2 (fetch from uncached space), while R5 and R6 still apply. In the R5 case with in_ifetch = 0, out_fault is 0.
- R8: A cycle with in_valid = 0 leaves out_paddr, out_uncache, out_strict and out_fault unchanged from the previous cycle.
- R9: out_fault never takes the value 3, and out_strict always equals out_uncache.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Request strobe |
| in_paddr | input | 44 | Translated physical address |
| in_ifetch | input | 1 | 1 = instruction fetch, 0 = data access |
| out_valid | output | 1 | Result valid, one clock after in_valid |
| out_paddr | output | 44 | Adjusted physical address |
| out_uncache | output | 1 | Access is uncacheable |
| out_strict | output | 1 | Access must be strictly ordered |
| out_fault | output | 2 | 0 none, 1 register space, 2 fetch from uncached space |

## Verification
The assertions are checked on every cycle. They cover the one-cycle valid timing, the hold of the data fields when no request is valid, and the cleared strip field whenever the uncacheable flag is set. They also cover the legal fault codes, and the mapping from each address class to its registered fault and flags one cycle later. Some behaviour can only be shown by the bench scenarios, which compare every output field against an independent model:
- the exact bit-for-bit address rewrite across random addresses;
- the register-window tag boundary (values 3'b110 against 3'b111);
- the priority of the register-space fault over the fetch fault;
- the values that are held across long runs of idle cycles.

// File: rtl/pa_filt_pkg.sv
package pa_filt_pkg;

  typedef enum logic [1:0] {
    FLT_NONE      = 2'd0,
    FLT_REGSPACE  = 2'd1,
    FLT_IFETCH_UC = 2'd2
  } pa_fault_e;

endpackage

// File: rtl/pa_filt_rst_sync.sv
module pa_filt_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_sync_n = sync_q[1];

endmodule

// File: rtl/pa_filt_classify.sv
module pa_filt_classify
  import pa_filt_pkg::*;
#(
  parameter int unsigned PA_W    = 44,
  parameter int unsigned UC_BIT  = 43,
  parameter int unsigned REG_LO  = 40,
  parameter int unsigned REG_TAG = 7
) (
  input  logic [PA_W-1:0] paddr,
  input  logic            ifetch,
  output logic            uc_hit,
  output logic            reg_hit,
  output logic            mark_uc,
  output pa_fault_e       fault
);

  localparam int unsigned TAG_W = UC_BIT - REG_LO;

  logic [TAG_W-1:0] tag_field;

  assign tag_field = paddr[UC_BIT-1:REG_LO];
  assign uc_hit    = paddr[UC_BIT];
  assign reg_hit   = uc_hit && (tag_field == TAG_W'(REG_TAG));

  always_comb begin
    mark_uc = uc_hit && !reg_hit;
    fault   = FLT_NONE;
    if (reg_hit) begin
      fault = FLT_REGSPACE;
    end else if (mark_uc && ifetch) begin
      fault = FLT_IFETCH_UC;
    end
  end

endmodule

// File: rtl/pa_filt_rewrite.sv
module pa_filt_rewrite #(
  parameter int unsigned PA_W     = 44,
  parameter int unsigned STRIP_HI = 42,
  parameter int unsigned STRIP_LO = 35
) (
  input  logic [PA_W-1:0] addr_in,
  input  logic            strip,
  output logic [PA_W-1:0] addr_out
);

  for (genvar b = 0; b < PA_W; b++) begin : g_bit
    if (b >= STRIP_LO && b <= STRIP_HI) begin : g_clr
      assign addr_out[b] = addr_in[b] & ~strip;
    end else begin : g_keep
      assign addr_out[b] = addr_in[b];
    end
  end

endmodule

// File: rtl/pa_filt_outreg.sv
module pa_filt_outreg
  import pa_filt_pkg::*;
#(
  parameter int unsigned PA_W = 44
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            in_valid,
  input  logic [PA_W-1:0] d_addr,
  input  logic            d_uncache,
  input  pa_fault_e       d_fault,
  output logic            q_valid,
  output logic [PA_W-1:0] q_addr,
  output logic            q_uncache,
  output logic            q_strict,
  output pa_fault_e       q_fault
);

  logic [PA_W-1:0] addr_nxt;
  logic            unc_nxt;
  logic            str_nxt;
  pa_fault_e       flt_nxt;

  always_comb begin
    addr_nxt = q_addr;
    unc_nxt  = q_uncache;
    str_nxt  = q_strict;
    flt_nxt  = q_fault;
    if (in_valid) begin
      addr_nxt = d_addr;
      unc_nxt  = d_uncache;
      str_nxt  = d_uncache;
      flt_nxt  = d_fault;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q_valid   <= 1'b0;
      q_addr    <= '0;
      q_uncache <= 1'b0;
      q_strict  <= 1'b0;
      q_fault   <= FLT_NONE;
    end else begin
      q_valid   <= in_valid;
      q_addr    <= addr_nxt;
      q_uncache <= unc_nxt;
      q_strict  <= str_nxt;
      q_fault   <= flt_nxt;
    end
  end

  p_valid_set_r2: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> q_valid);
  p_valid_clr_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !q_valid);
  p_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> ($stable(q_addr) && $stable(q_uncache) && $stable(q_strict) && $stable(q_fault)));

endmodule

// File: rtl/pa_cache_filter.sv
module pa_cache_filter
  import pa_filt_pkg::*;
#(
  parameter int unsigned PA_W     = 44,
  parameter int unsigned UC_BIT   = 43,
  parameter int unsigned REG_LO   = 40,
  parameter int unsigned REG_TAG  = 7,
  parameter int unsigned STRIP_HI = 42,
  parameter int unsigned STRIP_LO = 35
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            in_valid,
  input  logic [PA_W-1:0] in_paddr,
  input  logic            in_ifetch,
  output logic            out_valid,
  output logic [PA_W-1:0] out_paddr,
  output logic            out_uncache,
  output logic            out_strict,
  output logic [1:0]      out_fault
);

  localparam int unsigned TAG_W = UC_BIT - REG_LO;

  logic            rst_sync_n;
  logic            uc_hit;
  logic            reg_hit;
  logic            mark_uc;
  pa_fault_e       fault_d;
  pa_fault_e       fault_q;
  logic [PA_W-1:0] addr_d;

  pa_filt_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  pa_filt_classify #(
    .PA_W    (PA_W),
    .UC_BIT  (UC_BIT),
    .REG_LO  (REG_LO),
    .REG_TAG (REG_TAG)
  ) u_cls (
    .paddr   (in_paddr),
    .ifetch  (in_ifetch),
    .uc_hit  (uc_hit),
    .reg_hit (reg_hit),
    .mark_uc (mark_uc),
    .fault   (fault_d)
  );

  pa_filt_rewrite #(
    .PA_W     (PA_W),
    .STRIP_HI (STRIP_HI),
    .STRIP_LO (STRIP_LO)
  ) u_rw (
    .addr_in  (in_paddr),
    .strip    (mark_uc),
    .addr_out (addr_d)
  );

  pa_filt_outreg #(
    .PA_W (PA_W)
  ) u_reg (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .in_valid  (in_valid),
    .d_addr    (addr_d),
    .d_uncache (mark_uc),
    .d_fault   (fault_d),
    .q_valid   (out_valid),
    .q_addr    (out_paddr),
    .q_uncache (out_uncache),
    .q_strict  (out_strict),
    .q_fault   (fault_q)
  );

  assign out_fault = fault_q;

  logic in_tag;
  assign in_tag = (in_paddr[UC_BIT-1:REG_LO] == TAG_W'(REG_TAG));

  p_pass_r3: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (in_valid && !in_paddr[UC_BIT]) |=>
      (out_fault == 2'd0 && !out_uncache && out_paddr == $past(in_paddr)));
  p_regspace_r4: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (in_valid && in_paddr[UC_BIT] && in_tag) |=>
      (out_fault == 2'd1 && !out_uncache && out_paddr == $past(in_paddr)));
  p_uncache_r5: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (in_valid && in_paddr[UC_BIT] && !in_tag) |=> (out_uncache && out_strict));
  p_strip_r6: assert property (@(posedge clk) disable iff (!rst_sync_n)
    out_uncache |-> (out_paddr[STRIP_HI:STRIP_LO] == '0 && out_paddr[UC_BIT]));
  p_fetch_r7: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (in_valid && in_ifetch && in_paddr[UC_BIT] && !in_tag) |=> out_fault == 2'd2);
  p_code_r9: assert property (@(posedge clk) disable iff (!rst_sync_n)
    out_fault != 2'd3);
  p_pair_r9: assert property (@(posedge clk) disable iff (!rst_sync_n)
    out_strict == out_uncache);

endmodule

// File: tb/tb_pa_cache_filter.sv
`timescale 1ns/1ps
module tb_pa_cache_filter;

  logic        clk;
  logic        rst_n;
  logic        in_valid;
  logic [43:0] in_paddr;
  logic        in_ifetch;
  logic        out_valid;
  logic [43:0] out_paddr;
  logic        out_uncache;
  logic        out_strict;
  logic [1:0]  out_fault;

  int checks   = 0;
  int failures = 0;
  bit done     = 0;

  logic [43:0] e_addr;
  logic        e_unc;
  logic [1:0]  e_flt;

  pa_cache_filter dut (
    .clk         (clk),
    .rst_n       (rst_n),
    .in_valid    (in_valid),
    .in_paddr    (in_paddr),
    .in_ifetch   (in_ifetch),
    .out_valid   (out_valid),
    .out_paddr   (out_paddr),
    .out_uncache (out_uncache),
    .out_strict  (out_strict),
    .out_fault   (out_fault)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  function automatic logic is_reg(input logic [43:0] a);
    return a[43] && (a[42:40] == 3'b111);
  endfunction

  function automatic logic m_unc(input logic [43:0] a);
    return a[43] && !is_reg(a);
  endfunction

  function automatic logic [43:0] m_addr(input logic [43:0] a);
    logic [43:0] r;
    r = a;
    if (m_unc(a)) r[42:35] = 8'h00;
    return r;
  endfunction

  function automatic logic [1:0] m_flt(input logic [43:0] a, input logic f);
    if (is_reg(a)) return 2'd1;
    if (m_unc(a) && f) return 2'd2;
    return 2'd0;
  endfunction

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic string tag_of(input logic [43:0] a, input logic f, input logic v);
    if (!v) return "R8";
    if (!a[43]) return "R3";
    if (is_reg(a)) return "R4";
    if (f) return "R7";
    return "R6";
  endfunction

  task automatic apply(input logic v, input logic [43:0] a, input logic f);
    string t;
    @(negedge clk);
    in_valid  = v;
    in_paddr  = a;
    in_ifetch = f;
    if (v) begin
      e_addr = m_addr(a);
      e_unc  = m_unc(a);
      e_flt  = m_flt(a, f);
    end
    @(posedge clk);
    #1;
    t = tag_of(a, f, v);
    check("R2 out_valid", 64'(out_valid), 64'(v));
    check({t, " out_paddr"}, 64'(out_paddr), 64'(e_addr));
    check({t, " R5 out_uncache"}, 64'(out_uncache), 64'(e_unc));
    check({t, " R9 out_strict"}, 64'(out_strict), 64'(e_unc));
    check({t, " out_fault"}, 64'(out_fault), 64'(e_flt));
  endtask

  initial begin
    #(20 * 150000);
    if (!done) begin
      failures++;
      checks++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd5150));
    rst_n = 1'b0;
    in_valid = 1'b0;
    in_paddr = '0;
    in_ifetch = 1'b0;
    e_addr = '0;
    e_unc = 1'b0;
    e_flt = 2'd0;
    repeat (3) @(posedge clk);
    #1;
    check("R1 out_valid", 64'(out_valid), 64'd0);
    check("R1 out_paddr", 64'(out_paddr), 64'd0);
    check("R1 out_uncache", 64'(out_uncache), 64'd0);
    check("R1 out_strict", 64'(out_strict), 64'd0);
    check("R1 out_fault", 64'(out_fault), 64'd0);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(posedge clk);

    apply(1'b1, 44'h012_3456_789A, 1'b0);
    apply(1'b1, 44'h7FF_FFFF_FFFF, 1'b1);
    apply(1'b1, 44'hF00_0000_1000, 1'b0);
    apply(1'b1, 44'hF00_0000_1000, 1'b1);
    apply(1'b1, 44'hFFF_FFFF_FFFF, 1'b1);
    apply(1'b1, 44'hFFF_FFFF_FFFF, 1'b0);
    apply(1'b1, 44'hEFF_FFFF_FFFF, 1'b0);
    apply(1'b1, 44'hEFF_FFFF_FFFF, 1'b1);
    apply(1'b1, 44'h800_0000_0000, 1'b1);
    apply(1'b0, 44'h123_4567_89AB, 1'b1);
    apply(1'b0, 44'h000_0000_0000, 1'b0);
    apply(1'b1, 44'h8F8_0000_0007, 1'b0);

    for (int i = 0; i < 2000; i++) begin
      logic [43:0] a;
      logic [3:0]  sel;
      a   = {$urandom, $urandom};
      sel = 4'($urandom);
      if (sel < 4'd6) a[43] = 1'b1;
      if (sel == 4'd2 || sel == 4'd3) a[42:40] = 3'b111;
      if (sel == 4'd4) a[42:40] = 3'b110;
      apply(($urandom % 5) != 0, a, 1'($urandom));
    end

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule